// File: doc/BRIEF.md
# External Bus Cycle Strobe Generator

This block runs the control side of one external memory access at a time. A requester offers a cycle with an address, a read or write flag and two byte enables. The block captures it and steps through three bus states (T1, T2, T3) before it returns to idle (TI). During the cycle it drives four active-low strobes: an address latch strobe, a read strobe, and a write strobe for each byte lane. State changes on the rising clock edge. Every strobe is registered on the falling edge, so each strobe moves half a clock after the state that controls it begins.

A request offered while the block is in T3 starts the next T1 at once. Otherwise the block goes back to idle and keeps `ready` high until a request arrives.

The strobes also leave the block through eight shared pins. Each pin has a mode bit that picks either general port use or the bus-control function. In port mode, each pin has a direction bit that picks input or output.

Top module: `ext_bus_strobe`

## Requirements
- R1: During and right after reset, all four strobes are high, `ready` is 1 and every pad has `pad_oe` = 0 (port input, given mode and dir inputs of 0).
- R2: An accepted request (`req_valid` high while `ready` is high at a rising edge) runs T1, T2 and T3 in the next three cycles. `ready` is 1 only in TI and T3.
- R3: `ale_n` falls at the falling edge inside T1 and rises at the falling edge inside T3.
- R4: `rd_n` falls at the falling edge inside T1 and rises at the falling edge inside T3, for read cycles (`req_write` = 0) only. It is high whenever the bus is idle.
- R5: `lwr_n` falls at the falling edge inside T1 and rises at the falling edge inside T2, only for a write with `req_be[0]` = 1 (the lower byte).
- R6: `uwr_n` has the same timing as R5, only for a write with `req_be[1]` = 1 (the upper byte). With both enables set, both write strobes assert together.
- R7: A read ignores `req_be`. Neither write strobe asserts during a read, even with `req_be` = 2'b11.
- R8: A request accepted in T3 is followed directly by T1 with no idle cycle. `ale_n` goes high at the falling edge in T3 and low again at the falling edge in the new T1.
- R9: When `pin_mode[i]` = 1 (control), pad i is driven (`pad_oe[i]` = 1) with a control level. Pad 0 carries `lwr_n`, pad 1 `uwr_n`, pad 2 `rd_n` and pad 3 `ale_n`. Pads 4 to 7 are driven high.
- R10: When `pin_mode[i]` = 0 (port), `pad_oe[i]` = `pin_dir[i]` and `pad_out[i]` = `port_wdata[i]`. In every mode, `port_rdata[i]` is `pad_out[i]` when `pad_oe[i]` = 1 and `pad_in[i]` otherwise.
- R11: `bus_addr` holds the address captured at acceptance through T1, T2 and T3. Requests offered in T1 or T2 are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_addr | input | 16 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables, bit 0 lower, bit 1 upper |
| ready | output | 1 | Block can take a request this cycle |
| bus_addr | output | 16 | Captured cycle address |
| ale_n | output | 1 | Address latch strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| lwr_n | output | 1 | Lower-byte write strobe, active low |
| uwr_n | output | 1 | Upper-byte write strobe, active low |
| pin_mode | input | 8 | Per pad: 1 control, 0 port |
| pin_dir | input | 8 | Per pad in port mode: 1 output, 0 input |
| port_wdata | input | 8 | Port output levels |
| pad_in | input | 8 | Levels seen on the pads |
| pad_out | output | 8 | Levels driven on the pads |
| pad_oe | output | 8 | Pad drive enables |
| port_rdata | output | 8 | Per-pad readback |

## Verification
Two things can happen in the same cycle. The old cycle releases its address strobe in T3 while a new request is accepted for the next T1. The bench provokes this by holding `req_valid` high across several requests, so that acceptance falls in T3. It then checks that no idle cycle appears and that the strobes fall again half a clock into the new T1. The second overlap is a pin mode or direction change during an active strobe window. The bench judges this by comparing all eight pads every cycle against a model that places the strobes from its own state count.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_T1 = 2'd1, PH_T2 = 2'd2, PH_T3 = 2'd3} bus_phase_t;

  typedef struct packed {
    logic ale_n;
    logic rd_n;
    logic uwr_n;
    logic lwr_n;
  } strobes_t;

  localparam strobes_t STB_IDLE = '{ale_n: 1'b1, rd_n: 1'b1, uwr_n: 1'b1, lwr_n: 1'b1};

  // Strobe levels to take at the falling edge inside a given phase
  function automatic strobes_t strobe_levels(bus_phase_t ph, logic wr, logic [1:0] be);
    strobes_t s;
    logic open_long;
    logic open_short;
    open_long  = (ph == PH_T1) || (ph == PH_T2);
    open_short = (ph == PH_T1);
    s.ale_n = !open_long;
    s.rd_n  = !(open_long && !wr);
    s.lwr_n = !(open_short && wr && be[0]);
    s.uwr_n = !(open_short && wr && be[1]);
    return s;
  endfunction

  // Control level for a given pad index
  function automatic logic pad_ctl_level(int idx, strobes_t s);
    case (idx)
      0: return s.lwr_n;
      1: return s.uwr_n;
      2: return s.rd_n;
      3: return s.ale_n;
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/ebs_seq.sv
module ebs_seq
  import ebs_pkg::*;
#(
  parameter int AW = 16,
  parameter int BEW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [AW-1:0]  req_addr,
  input  logic           req_write,
  input  logic [BEW-1:0] req_be,
  output logic           ready,
  output logic           accept,
  output bus_phase_t     phase,
  output logic           cur_write,
  output logic [BEW-1:0] cur_be,
  output logic [AW-1:0]  cur_addr
);
  bus_phase_t phase_d;

  assign ready  = (phase == PH_IDLE) || (phase == PH_T3);
  assign accept = ready && req_valid;

  always_comb begin
    case (phase)
      PH_T1:   phase_d = PH_T2;
      PH_T2:   phase_d = PH_T3;
      default: phase_d = accept ? PH_T1 : PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cur_write <= 1'b0;
      cur_be    <= '0;
      cur_addr  <= '0;
    end else begin
      phase <= phase_d;
      if (accept) begin
        cur_write <= req_write;
        cur_be    <= req_be;
        cur_addr  <= req_addr;
      end
    end
  end
endmodule

// File: rtl/ebs_strobe.sv
module ebs_strobe
  import ebs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bus_phase_t phase,
  input  logic       cur_write,
  input  logic [1:0] cur_be,
  output strobes_t   stb
);
  strobes_t stb_d;

  assign stb_d = strobe_levels(phase, cur_write, cur_be);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) stb <= STB_IDLE;
    else        stb <= stb_d;
  end
endmodule

// File: rtl/ebs_pinmux.sv
module ebs_pinmux
  import ebs_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  strobes_t        stb,
  input  logic [NPIN-1:0] pin_mode,
  input  logic [NPIN-1:0] pin_dir,
  input  logic [NPIN-1:0] port_wdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] port_rdata
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pad
    assign pad_oe[i]     = pin_mode[i] | pin_dir[i];
    assign pad_out[i]    = pin_mode[i] ? pad_ctl_level(i, stb) : port_wdata[i];
    assign port_rdata[i] = pad_oe[i] ? pad_out[i] : pad_in[i];
  end
endmodule

// File: rtl/ext_bus_strobe.sv
module ext_bus_strobe
  import ebs_pkg::*;
#(
  parameter int AW = 16,
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_write,
  input  logic [1:0]      req_be,
  output logic            ready,
  output logic [AW-1:0]   bus_addr,
  output logic            ale_n,
  output logic            rd_n,
  output logic            lwr_n,
  output logic            uwr_n,
  input  logic [NPIN-1:0] pin_mode,
  input  logic [NPIN-1:0] pin_dir,
  input  logic [NPIN-1:0] port_wdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] port_rdata
);
  bus_phase_t phase;
  logic       accept;
  logic       cur_write;
  logic [1:0] cur_be;
  strobes_t   stb;

  // Named phase events for the checker
  logic st_idle, st_t1, st_t2, st_t3;
  assign st_idle = (phase == PH_IDLE);
  assign st_t1   = (phase == PH_T1);
  assign st_t2   = (phase == PH_T2);
  assign st_t3   = (phase == PH_T3);

  ebs_seq #(.AW(AW), .BEW(2)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_be(req_be), .ready(ready), .accept(accept),
    .phase(phase), .cur_write(cur_write), .cur_be(cur_be), .cur_addr(bus_addr)
  );

  ebs_strobe u_stb (
    .clk(clk), .rst_n(rst_n), .phase(phase), .cur_write(cur_write),
    .cur_be(cur_be), .stb(stb)
  );

  assign ale_n = stb.ale_n;
  assign rd_n  = stb.rd_n;
  assign lwr_n = stb.lwr_n;
  assign uwr_n = stb.uwr_n;

  ebs_pinmux #(.NPIN(NPIN)) u_pins (
    .stb(stb), .pin_mode(pin_mode), .pin_dir(pin_dir), .port_wdata(port_wdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .port_rdata(port_rdata)
  );
endmodule

// File: rtl/ext_bus_strobe_chk.sv
module ext_bus_strobe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       st_idle,
  input logic       st_t1,
  input logic       st_t2,
  input logic       st_t3,
  input logic       accept,
  input logic       cur_write,
  input logic [1:0] cur_be,
  input logic       ale_n,
  input logic       rd_n,
  input logic       lwr_n,
  input logic       uwr_n
);
  a_r2_t1_to_t2: assert property (@(posedge clk) disable iff (!rst_n) st_t1 |=> st_t2);
  a_r2_t2_to_t3: assert property (@(posedge clk) disable iff (!rst_n) st_t2 |=> st_t3);
  a_r8_chain: assert property (@(posedge clk) disable iff (!rst_n) (st_t3 && accept) |=> st_t1);
  a_r3_ale_window: assert property (@(posedge clk) disable iff (!rst_n) !ale_n |-> (st_t1 || st_t2));
  a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> (rd_n && ale_n && lwr_n && uwr_n));
  a_r4_rd_read_only: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !cur_write);
  a_r5_lwr_lane: assert property (@(posedge clk) disable iff (!rst_n) !lwr_n |-> (cur_write && cur_be[0]));
  a_r6_uwr_lane: assert property (@(posedge clk) disable iff (!rst_n) !uwr_n |-> (cur_write && cur_be[1]));
  a_r7_no_mix: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && (!lwr_n || !uwr_n)));
endmodule

bind ext_bus_strobe ext_bus_strobe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st_idle(st_idle), .st_t1(st_t1), .st_t2(st_t2),
  .st_t3(st_t3), .accept(accept), .cur_write(cur_write), .cur_be(cur_be),
  .ale_n(ale_n), .rd_n(rd_n), .lwr_n(lwr_n), .uwr_n(uwr_n)
);

// File: tb/ext_bus_strobe_bench.sv
module ext_bus_strobe_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = CLK_PERIOD / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic req_write = 1'b0;
  logic [1:0] req_be = '0;
  logic ready;
  logic [15:0] bus_addr;
  logic ale_n, rd_n, lwr_n, uwr_n;
  logic [7:0] pin_mode = '0, pin_dir = '0, port_wdata = '0, pad_in = 8'h5A;
  logic [7:0] pad_out, pad_oe, port_rdata;

  int checks = 0;
  int bad = 0;
  int cycles = 0;

  // Reference model state
  int m_ph = 0;
  int m_wr = 0;
  int m_be = 0;
  int m_addr = 0;
  bit m_took = 0;
  int phase_log[$];

  ext_bus_strobe u_ext_bus_strobe (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_be(req_be), .ready(ready), .bus_addr(bus_addr),
    .ale_n(ale_n), .rd_n(rd_n), .lwr_n(lwr_n), .uwr_n(uwr_n),
    .pin_mode(pin_mode), .pin_dir(pin_dir), .port_wdata(port_wdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .port_rdata(port_rdata)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // Model steps at every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_took = 0;
    end else begin
      m_took = 0;
      if (m_ph == 1) m_ph = 2;
      else if (m_ph == 2) m_ph = 3;
      else if (req_valid) begin
        m_ph = 1; m_took = 1;
        m_wr = int'(req_write); m_be = int'(req_be); m_addr = int'(req_addr);
      end else m_ph = 0;
      phase_log.push_back(m_ph);
    end
  end

  // Compare a quarter clock after each falling edge
  always @(negedge clk) begin
    #(Q);
    if (rst_n) begin
      int e_ale, e_rd, e_lwr, e_uwr, e_rdy;
      bit in_cyc;
      in_cyc = (m_ph == 1 || m_ph == 2);
      e_ale = in_cyc ? 0 : 1;
      e_rd  = (in_cyc && m_wr == 0) ? 0 : 1;
      e_lwr = (m_ph == 1 && m_wr == 1 && m_be[0]) ? 0 : 1;
      e_uwr = (m_ph == 1 && m_wr == 1 && m_be[1]) ? 0 : 1;
      e_rdy = (m_ph == 0 || m_ph == 3) ? 1 : 0;
      check("R2 ready", int'(ready), e_rdy);
      check("R3 ale_n", int'(ale_n), e_ale);
      check("R4 rd_n", int'(rd_n), e_rd);
      check("R5 lwr_n", int'(lwr_n), e_lwr);
      check("R6 uwr_n", int'(uwr_n), e_uwr);
      if (m_ph != 0) check("R11 bus_addr", int'(bus_addr), m_addr);
      for (int i = 0; i < 8; i++) begin
        int lvl, oe;
        case (i)
          0: lvl = e_lwr;
          1: lvl = e_uwr;
          2: lvl = e_rd;
          3: lvl = e_ale;
          default: lvl = 1;
        endcase
        if (pin_mode[i]) begin
          oe = 1;
          check("R9 pad_oe", int'(pad_oe[i]), 1);
          check("R9 pad_out", int'(pad_out[i]), lvl);
        end else begin
          oe = int'(pin_dir[i]);
          lvl = int'(port_wdata[i]);
          check("R10 pad_oe", int'(pad_oe[i]), oe);
          if (oe == 1) check("R10 pad_out", int'(pad_out[i]), lvl);
        end
        check("R10 port_rdata", int'(port_rdata[i]), oe == 1 ? lvl : int'(pad_in[i]));
      end
    end
  end

  // Offer a request and hold it until the model has taken it
  task automatic offer(input logic [15:0] a, input logic w, input logic [1:0] be);
    req_valid = 1'b1; req_addr = a; req_write = w; req_be = be;
    do begin
      @(posedge clk); #(Q);
    end while (!m_took);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #(Q);
    end
  endtask

  initial begin
    #(Q);
    #(CLK_PERIOD * 2);
    // R1 reset state
    check("R1 ale_n", int'(ale_n), 1);
    check("R1 rd_n", int'(rd_n), 1);
    check("R1 lwr_n", int'(lwr_n), 1);
    check("R1 uwr_n", int'(uwr_n), 1);
    check("R1 ready", int'(ready), 1);
    check("R1 pad_oe", int'(pad_oe), 0);
    check("R10 port_rdata in", int'(port_rdata), 8'h5A);
    @(posedge clk); #(Q);
    rst_n = 1'b1;
    idle(2);
    check("R1 ready after reset", int'(ready), 1);
    pin_mode = 8'h0F;
    offer(16'h1234, 1'b0, 2'b00);  // R4 read
    idle(4);
    offer(16'h2000, 1'b1, 2'b01);  // R5 lower write
    idle(4);
    offer(16'h2002, 1'b1, 2'b10);  // R6 upper write
    idle(3);
    offer(16'h2004, 1'b1, 2'b11);  // R6 both lanes
    idle(3);
    offer(16'h3000, 1'b0, 2'b11);  // R7 read with enables set
    idle(4);
    pin_mode = 8'hF0; pin_dir = 8'h0C; port_wdata = 8'hA5;
    // R8 back-to-back chain, R11 requests held through T1/T2
    phase_log.delete();
    offer(16'h4000, 1'b1, 2'b01);
    offer(16'h4002, 1'b0, 2'b00);
    offer(16'h4004, 1'b1, 2'b10);
    idle(4);
    check("R8 chain phases", phase_log.size() >= 9 ? phase_log[3] : -1, 1);
    check("R8 chain phases 2", phase_log.size() >= 9 ? phase_log[6] : -1, 1);
    // R9/R10: pin config changes during active strobes
    offer(16'h5555, 1'b1, 2'b11);
    pin_mode = 8'h3C; pin_dir = 8'hC3; port_wdata = 8'h0F;
    idle(1);
    pin_mode = 8'hFF;
    idle(2);
    pin_mode = 8'h00; pin_dir = 8'h00;
    offer(16'h6666, 1'b0, 2'b01);
    pin_mode = 8'h0F;
    idle(5);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        bad++; checks++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
      end
    end
  end
endmodule